// File: doc/BRIEF.md
# Compressed Byte/Halfword Instruction Expander

This block turns one 16-bit compressed instruction into the 32-bit base instruction that does the same work. It covers two encoding families. The first is the narrow memory forms: unsigned byte load, signed and unsigned halfword load, byte store and halfword store, each with a 2-bit unsigned offset. The second is a set of single-register operations: zero-extend and sign-extend of a byte or halfword, zero-extend of a word, bitwise NOT, and a two-register multiply.

The unit is purely combinational and sits in a decode stage next to the other compressed-instruction expanders. A flag tells it whether the core runs with a 64-bit register width. That flag changes the expansion of the halfword zero-extend, and it decides whether the word zero-extend is legal. Any 16-bit word outside these two families, and any reserved sub-encoding inside them, raises the illegal flag and gives an all-zero expansion.

Top module: `cbh_expander`

## Requirements
- R1: A word with bits[1:0]=00 and bits[15:10]=100000 expands to an unsigned byte load (funct3 100, opcode 0000011). Its offset bit 0 is taken from instruction bit 6 and its offset bit 1 from instruction bit 5.
- R2: A word with bits[1:0]=00 and bits[15:10]=100001 expands to a halfword load. Offset bit 1 comes from bit 5 and offset bit 0 is zero. Bit 6 = 1 gives a signed load (funct3 001) and bit 6 = 0 gives an unsigned load (funct3 101).
- R3: A word with bits[1:0]=00 and bits[15:10]=100010 expands to a byte store (funct3 000, opcode 0100011) with the same offset bit order as R1. The data register comes from bits 4-2 and the base register from bits 9-7.
- R4: A word with bits[1:0]=00 and bits[15:10]=100011 expands to a halfword store (funct3 001) with offset bit 1 from bit 5 when bit 6 = 0. With bit 6 = 1 it is illegal.
- R5: Quadrant 01 with bits[15:10]=100111 and bits[6:2]=11000 expands to ANDI rd,rd,255.
- R6: Function code 11001 expands to a byte sign-extend (I-type, imm 0x604, funct3 001) and function code 11011 to a halfword sign-extend (imm 0x605), both on rd,rd.
- R7: Function code 11010 expands to a halfword zero-extend: funct7 0000100, rs2 x0, funct3 100. Its opcode is 0110011 when the 64-bit flag is 0 and 0111011 when it is 1.
- R8: Function code 11100 expands to ADD.UW rd,rd,x0 (funct7 0000100, funct3 000, opcode 0111011) only when the 64-bit flag is 1. Otherwise it is illegal.
- R9: Function code 11101 expands to XORI rd,rd,-1.
- R10: Quadrant 01 with bits[15:10]=100111 and bits[6:5]=10 expands to MUL rd,rd,rs2 (funct7 0000001, funct3 000, opcode 0110011).
- R11: Any other word, and any other value of bits[6:2] in the unary group, sets the illegal flag and gives an all-zero expansion. A legal expansion always has bits[1:0]=11.
- R12: A 3-bit register field r names register 8+r. rd and rs1 come from bits 9-7, except in the memory forms, where bits 9-7 give the base register and bits 4-2 give the data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cinstr_i | input | 16 | Compressed instruction word |
| xlen64_i | input | 1 | High when the core has a 64-bit register width |
| instr_o | output | 32 | Expanded base instruction, zero when illegal |
| illegal_o | output | 1 | High when the input is not a supported encoding |

## Verification
The assertions check, on every evaluation, properties that hold for every input. A legal expansion always has a compressed-range base register and the 32-bit low bits. An illegal result is always all zeros. A word zero-extend only appears with the 64-bit flag set. Every unary result writes back to its own source. A memory load offset never leaves the 2-bit range. The exact field placement, such as the swapped byte-offset bits, the signedness choice from bit 6 and the width-dependent opcode, can only be shown by comparing whole expanded words. The bench does this with a model of its own, over directed corner words and random words biased into both families.

// File: rtl/cbh_pkg.sv
package cbh_pkg;
  localparam int CLEN = 16;
  localparam int ILEN = 32;
  localparam int RIDX = 5;
  localparam int CRIDX = 3;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_OP    = 7'b0110011;
  localparam logic [6:0] OPC_OP32  = 7'b0111011;

  localparam logic [1:0] QD_MEM = 2'b00;
  localparam logic [1:0] QD_ALU = 2'b01;

  typedef struct packed {
    logic            hit;
    logic            bad;
    logic [ILEN-1:0] word;
  } xlat_t;

  function automatic logic [RIDX-1:0] widen_reg(input logic [CRIDX-1:0] r);
    return {2'b01, r};
  endfunction

  function automatic logic [ILEN-1:0] mk_itype(input logic [11:0] imm,
      input logic [RIDX-1:0] rs1, input logic [2:0] f3,
      input logic [RIDX-1:0] rd, input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [ILEN-1:0] mk_rtype(input logic [6:0] f7,
      input logic [RIDX-1:0] rs2, input logic [RIDX-1:0] rs1,
      input logic [2:0] f3, input logic [RIDX-1:0] rd, input logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  function automatic logic [ILEN-1:0] mk_stype(input logic [11:0] imm,
      input logic [RIDX-1:0] rs2, input logic [RIDX-1:0] rs1,
      input logic [2:0] f3, input logic [6:0] opc);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
  endfunction
endpackage

// File: rtl/cbh_mem_expand.sv
module cbh_mem_expand
  import cbh_pkg::*;
(
  input  logic [CLEN-1:0] cinstr_i,
  output xlat_t           res_o
);
  logic [RIDX-1:0] base_reg;
  logic [RIDX-1:0] data_reg;
  logic [1:0]      sel;
  logic [11:0]     boff;
  logic [11:0]     hoff;

  assign base_reg = widen_reg(cinstr_i[9:7]);
  assign data_reg = widen_reg(cinstr_i[4:2]);
  assign sel      = cinstr_i[11:10];
  assign boff     = {10'b0, cinstr_i[5], cinstr_i[6]};
  assign hoff     = {10'b0, cinstr_i[5], 1'b0};

  always_comb begin
    res_o.hit  = (cinstr_i[1:0] == QD_MEM) && (cinstr_i[15:12] == 4'b1000);
    res_o.bad  = 1'b0;
    res_o.word = '0;
    if (res_o.hit) begin
      unique case (sel)
        2'b00: res_o.word = mk_itype(boff, base_reg, 3'b100, data_reg, OPC_LOAD);
        2'b01: res_o.word = mk_itype(hoff, base_reg,
                                     cinstr_i[6] ? 3'b001 : 3'b101, data_reg, OPC_LOAD);
        2'b10: res_o.word = mk_stype(boff, data_reg, base_reg, 3'b000, OPC_STORE);
        default: begin
          res_o.bad  = cinstr_i[6];
          res_o.word = mk_stype(hoff, data_reg, base_reg, 3'b001, OPC_STORE);
        end
      endcase
    end
  end

  always_comb begin
    if (res_o.hit && !res_o.bad && res_o.word[6:0] == OPC_LOAD)
      AST_LOAD_OFFSET_RANGE: assert (res_o.word[31:22] == '0) else $error("load offset out of range"); // R1
    if (res_o.bad)
      AST_BAD_ONLY_HSTORE: assert (sel == 2'b11 && cinstr_i[6]) else $error("bad memory form"); // R4
  end
endmodule

// File: rtl/cbh_alu_expand.sv
module cbh_alu_expand
  import cbh_pkg::*;
(
  input  logic [CLEN-1:0] cinstr_i,
  input  logic            xlen64_i,
  output xlat_t           res_o
);
  localparam logic [4:0] FN_ZEXTB = 5'b11000;
  localparam logic [4:0] FN_SEXTB = 5'b11001;
  localparam logic [4:0] FN_ZEXTH = 5'b11010;
  localparam logic [4:0] FN_SEXTH = 5'b11011;
  localparam logic [4:0] FN_ZEXTW = 5'b11100;
  localparam logic [4:0] FN_NOT   = 5'b11101;

  logic [RIDX-1:0] dst_reg;
  logic [RIDX-1:0] src2_reg;
  logic [4:0]      fn;

  assign dst_reg  = widen_reg(cinstr_i[9:7]);
  assign src2_reg = widen_reg(cinstr_i[4:2]);
  assign fn       = cinstr_i[6:2];

  always_comb begin
    res_o.hit  = (cinstr_i[1:0] == QD_ALU) && (cinstr_i[15:10] == 6'b100111);
    res_o.bad  = 1'b0;
    res_o.word = '0;
    if (res_o.hit) begin
      if (cinstr_i[6:5] == 2'b10) begin
        res_o.word = mk_rtype(7'b0000001, src2_reg, dst_reg, 3'b000, dst_reg, OPC_OP);
      end else begin
        unique case (fn)
          FN_ZEXTB: res_o.word = mk_itype(12'h0FF, dst_reg, 3'b111, dst_reg, OPC_OPIMM);
          FN_SEXTB: res_o.word = mk_itype(12'h604, dst_reg, 3'b001, dst_reg, OPC_OPIMM);
          FN_SEXTH: res_o.word = mk_itype(12'h605, dst_reg, 3'b001, dst_reg, OPC_OPIMM);
          FN_ZEXTH: res_o.word = mk_rtype(7'b0000100, '0, dst_reg, 3'b100, dst_reg,
                                          xlen64_i ? OPC_OP32 : OPC_OP);
          FN_ZEXTW: begin
            res_o.bad  = !xlen64_i;
            res_o.word = mk_rtype(7'b0000100, '0, dst_reg, 3'b000, dst_reg, OPC_OP32);
          end
          FN_NOT:   res_o.word = mk_itype(12'hFFF, dst_reg, 3'b100, dst_reg, OPC_OPIMM);
          default:  res_o.bad = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    if (res_o.hit && !res_o.bad)
      AST_ALU_WRITES_SOURCE: assert (res_o.word[11:7] == res_o.word[19:15]) else $error("rd differs from rs1"); // R5
  end
endmodule

// File: rtl/cbh_expander.sv
module cbh_expander
  import cbh_pkg::*;
(
  input  logic [15:0] cinstr_i,
  input  logic        xlen64_i,
  output logic [31:0] instr_o,
  output logic        illegal_o
);
  xlat_t mem_res;
  xlat_t alu_res;
  logic  mem_ok;
  logic  alu_ok;

  cbh_mem_expand u_mem (
    .cinstr_i (cinstr_i),
    .res_o    (mem_res)
  );

  cbh_alu_expand u_alu (
    .cinstr_i (cinstr_i),
    .xlen64_i (xlen64_i),
    .res_o    (alu_res)
  );

  assign mem_ok = mem_res.hit && !mem_res.bad;
  assign alu_ok = alu_res.hit && !alu_res.bad;

  always_comb begin
    illegal_o = !(mem_ok || alu_ok);
    instr_o   = '0;
    if (mem_ok)      instr_o = mem_res.word;
    else if (alu_ok) instr_o = alu_res.word;
  end

  always_comb begin
    AST_ONE_FAMILY: assert (!(mem_res.hit && alu_res.hit)) else $error("two families hit"); // R11
    if (!illegal_o) begin
      AST_LEGAL_LOWBITS: assert (instr_o[1:0] == 2'b11) else $error("legal word lacks 32-bit marker"); // R11
      AST_BASE_REG_RANGE: assert (instr_o[19:18] == 2'b01) else $error("rs1 outside x8..x15"); // R12
      if (instr_o[6:0] == OPC_OP32 && instr_o[14:12] == 3'b000)
        AST_ZEXTW_NEEDS_64: assert (xlen64_i) else $error("word zero-extend on 32-bit"); // R8
    end
  end
endmodule

// File: tb/cbh_expander_bench.sv
`timescale 1ns/1ps
module cbh_expander_bench;
  logic        clk;
  logic [15:0] cinstr;
  logic        xlen64;
  logic [31:0] instr;
  logic        illegal;
  int          checks;
  int          errors;
  bit          done;

  cbh_expander u_cbh_expander (
    .cinstr_i  (cinstr),
    .xlen64_i  (xlen64),
    .instr_o   (instr),
    .illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic void model(input logic [15:0] c, input logic x64,
                                output logic [31:0] w, output logic ill, output string tag);
    logic [4:0] ra;
    logic [4:0] rb;
    ra  = {2'b01, c[9:7]};
    rb  = {2'b01, c[4:2]};
    w   = 32'h0;
    ill = 1'b0;
    tag = "R11";
    casez (c)
      16'b100000??_??????00: begin tag = "R1"; w = {10'b0, c[5], c[6], ra, 3'b100, rb, 7'h03}; end
      16'b100001??_??????00: begin tag = "R2"; w = {10'b0, c[5], 1'b0, ra, (c[6] ? 3'b001 : 3'b101), rb, 7'h03}; end
      16'b100010??_??????00: begin tag = "R3"; w = {7'b0, rb, ra, 3'b000, 3'b0, c[5], c[6], 7'h23}; end
      16'b100011??_??????00: begin
        tag = "R4";
        if (c[6]) ill = 1'b1;
        else w = {7'b0, rb, ra, 3'b001, 3'b0, c[5], 1'b0, 7'h23};
      end
      16'b100111??_?10???01: begin tag = "R10"; w = {7'b0000001, rb, ra, 3'b000, ra, 7'h33}; end
      16'b100111??_?11???01: begin
        case (c[4:2])
          3'd0: begin tag = "R5"; w = {12'h0FF, ra, 3'b111, ra, 7'h13}; end
          3'd1: begin tag = "R6"; w = {12'h604, ra, 3'b001, ra, 7'h13}; end
          3'd2: begin tag = "R7"; w = {7'b0000100, 5'd0, ra, 3'b100, ra, (x64 ? 7'h3B : 7'h33)}; end
          3'd3: begin tag = "R6"; w = {12'h605, ra, 3'b001, ra, 7'h13}; end
          3'd4: begin
            tag = "R8";
            if (x64) w = {7'b0000100, 5'd0, ra, 3'b000, ra, 7'h3B};
            else ill = 1'b1;
          end
          3'd5: begin tag = "R9"; w = {12'hFFF, ra, 3'b100, ra, 7'h13}; end
          default: ill = 1'b1;
        endcase
      end
      default: ill = 1'b1;
    endcase
  endfunction

  task automatic run(input logic [15:0] c, input logic x64, input string tag_ovr);
    logic [31:0] ew;
    logic        eill;
    string       tag;
    @(negedge clk);
    cinstr = c;
    xlen64 = x64;
    #1;
    model(c, x64, ew, eill, tag);
    if (tag_ovr != "") tag = tag_ovr;
    checks++;
    if (instr !== ew || illegal !== eill) begin
      errors++;
      $display("FAIL %s in=%h x64=%0d got=%h/%0d exp=%h/%0d", tag, c, x64, instr, illegal, ew, eill);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    cinstr = 16'h0;
    xlen64 = 1'b0;
    void'($urandom(32'd20240611));
    run(16'h0000, 1'b0, "R11");
    run(16'b100000_000_1_0_000_00, 1'b0, "R1");
    run(16'b100000_000_0_1_000_00, 1'b0, "R1");
    run(16'b100001_101_1_1_010_00, 1'b0, "R2");
    run(16'b100001_101_0_1_010_00, 1'b1, "R2");
    run(16'b100010_011_1_0_110_00, 1'b0, "R3");
    run(16'b100011_011_0_1_110_00, 1'b0, "R4");
    run(16'b100011_011_1_1_110_00, 1'b0, "R4");
    run(16'b100111_010_11000_01, 1'b0, "R5");
    run(16'b100111_010_11001_01, 1'b0, "R6");
    run(16'b100111_010_11011_01, 1'b1, "R6");
    run(16'b100111_100_11010_01, 1'b0, "R7");
    run(16'b100111_100_11010_01, 1'b1, "R7");
    run(16'b100111_001_11100_01, 1'b0, "R8");
    run(16'b100111_001_11100_01, 1'b1, "R8");
    run(16'b100111_111_11101_01, 1'b0, "R9");
    run(16'b100111_011_10101_01, 1'b1, "R10");
    run(16'b100111_011_11110_01, 1'b1, "R11");
    run(16'b100111_011_00101_01, 1'b1, "R11");
    run(16'b100000_111_1_1_111_10, 1'b0, "R11");
    run(16'b100111_111_10000_01, 1'b0, "R12");
    run(16'b100000_000_0_0_000_00, 1'b0, "R12");
    for (int i = 0; i < 3000; i++) begin
      r = 16'($urandom);
      case ($urandom % 3)
        0: r = {4'b1000, r[11:2], 2'b00};
        1: r = {6'b100111, r[9:2], 2'b01};
        default: ;
      endcase
      run(r, 1'($urandom), "");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule